// File: doc/BRIEF.md
# Banked Real-Time-Clock Register File

This block holds the host-visible nibble registers of a real-time clock. A host port with a 4-bit address reaches 16 locations. Two bits of the control nibble at address F choose which of three banks answers at addresses 0 to D and at the low half of address E. Bank 0 holds the time and calendar digits, including a four-digit BCD year. Bank 1 holds alarm and frequency-output settings together with spare RAM. Bank 2 holds correction, timer and spare RAM. The control nibble and the top two bits of address E are single registers that every bank sees.

Each location has a per-bank write mask. Bits that are fixed at zero drop writes and read 0. The timer count is brought in from outside and read back at bank 2 addresses 6 and 7, which ignore host writes. A prescaler counts 32.768 kHz ticks. It emits a one-cycle update strobe every second and raises a busy flag for the last few ticks before each strobe. The host reads that flag at address F bit 0. Writing a 1 to the same bit issues an adjust pulse instead and does not change busy.

Top module: `rtc_bank_regfile`

## Requirements
- R1: Control bits F[3:2] select the bank (0, 1, 2). The same address in different banks is separate storage, and no storage changes while we_i is low.
- R2: F[3:0] and E[3:2] are one shared set of bits. A write from any bank is read back identically from every other bank. F bit 1 is a plain read/write stop bit, driven on stop_o.
- R3: A read of F bit 0 returns busy_o. A write to F with bit 0 set produces a single-cycle adj_o pulse in the cycle after the write and leaves busy unchanged.
- R4: With TICKS_PER_SEC=N and BUSY_TICKS=B, counting ticks from reset, busy_o is 1 while the tick count within the second is N-B or more. The tick that completes the second clears busy_o, and upd_o is 1 for exactly the following cycle.
- R5: Bank 2 address 6 reads tmr_cnt_i[3:0] and address 7 reads tmr_cnt_i[7:4]. Host writes to either address have no effect.
- R6: Fixed-zero bits read 0 and ignore writes. In bank 0 these are: address 3 bit 3, addresses 5 and 8 bits 3:2, address 6 bit 3, address A bits 3:1. In bank 1 they are address C bit 3 and address D bit 2. In bank 2 they are addresses 2, 3, 9 and A.
- R7: Bank 1 addresses 9 to B and bank 2 addresses B to D store a full nibble.
- R8: After reset, the bank is 0, every readable bit is 0, and bank 0 address 1 bit 3 (oscillator-stop flag) is 1.
- R9: With bank code 3 selected, addresses 0 to D and E[1:0] read 0 and ignore writes, while the shared bits stay accessible.
- R10: E[1:0] is banked: the year thousands digit in bank 0 and flag/enable pairs in banks 1 and 2, each kept separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power application) |
| tick_i | input | 1 | 32.768 kHz tick enable, one clock wide |
| we_i | input | 1 | Host write enable, single cycle |
| addr_i | input | 4 | Host register address |
| wdata_i | input | 4 | Host write data |
| tmr_cnt_i | input | 8 | Live timer count shown at bank 2 addresses 6/7 |
| rdata_o | output | 4 | Combinational read data for addr_i in the current bank |
| busy_o | output | 1 | Busy flag ahead of the second update |
| upd_o | output | 1 | One-cycle strobe for each second update |
| adj_o | output | 1 | One-cycle adjust command pulse |
| stop_o | output | 1 | Stop control bit |

## Verification
The hardest behaviour to reach is the busy window. It only appears near the end of a second and is visible only through address F bit 0. To reach it, the bench builds the block with a 64-tick second and drives the tick on every clock. It then walks past two full seconds and compares busy_o, upd_o and the F read against a tick count it keeps itself. Bank code 3 and the shared bits are reached by writes to F from different banks, each followed by read-back from the other banks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NIB_W    = 4;
  localparam int ADDR_W   = 4;
  localparam int N_BANK   = 3;
  localparam int N_BANKED = 15;            // addresses 0..E carry banked storage
  localparam int TMR_W    = 2 * NIB_W;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'hF;
  localparam logic [ADDR_W-1:0] A_EXT  = 4'hE;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/rtc_access_map.sv
module rtc_access_map
  import rtc_pkg::*;
(
  input  logic [1:0]        bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output nib_t              mask_o,   // writable/readable banked bits
  output logic              tmr_ro_o  // read-only timer window
);
  always_comb begin
    mask_o   = '0;
    tmr_ro_o = 1'b0;
    unique case (bank_i)
      2'd0: unique case (addr_i)
        4'h3, 4'h6:       mask_o = 4'b0111;
        4'h5, 4'h8:       mask_o = 4'b0011;
        4'hA:             mask_o = 4'b0001;
        4'hE:             mask_o = 4'b0011;
        4'hF:             mask_o = 4'b0000;
        default:          mask_o = 4'b1111;
      endcase
      2'd1: unique case (addr_i)
        4'hC:             mask_o = 4'b0111;
        4'hD:             mask_o = 4'b1011;
        4'hE:             mask_o = 4'b0011;
        4'hF:             mask_o = 4'b0000;
        default:          mask_o = 4'b1111;
      endcase
      2'd2: unique case (addr_i)
        4'h2, 4'h3, 4'h9, 4'hA, 4'hF: mask_o = 4'b0000;
        4'h6, 4'h7: begin
          mask_o   = 4'b0000;
          tmr_ro_o = 1'b1;
        end
        4'hE:             mask_o = 4'b0011;
        default:          mask_o = 4'b1111;
      endcase
      default:            mask_o = 4'b0000;
    endcase
  end
endmodule

// File: rtl/rtc_busy_gen.sv
module rtc_busy_gen #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_TICKS    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic busy_o,
  output logic upd_o
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] BSTART = CW'(TICKS_PER_SEC - BUSY_TICKS);

  logic [CW-1:0] cnt_q;
  logic          upd_q;
  logic          wrap;

  assign wrap = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= wrap;
      if (wrap)        cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = (cnt_q >= BSTART);
  assign upd_o  = upd_q;

  p_busy_off_at_upd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> !busy_o);
  p_busy_ends_with_upd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> upd_o);
endmodule

// File: rtl/rtc_shared_ctrl.sv
module rtc_shared_ctrl
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  nib_t              wdata_i,
  output logic [1:0]        bank_o,
  output logic              stop_o,
  output logic              test_o,
  output logic              temp_o,
  output logic              adj_o
);
  logic [1:0] bank_q;
  logic       stop_q, test_q, temp_q, adj_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      stop_q <= 1'b0;
      test_q <= 1'b0;
      temp_q <= 1'b0;
      adj_q  <= 1'b0;
    end else begin
      adj_q <= 1'b0;
      if (we_i && addr_i == A_CTRL) begin
        bank_q <= wdata_i[3:2];
        stop_q <= wdata_i[1];
        adj_q  <= wdata_i[0];        // bit 0 write is a command, not storage
      end
      if (we_i && addr_i == A_EXT) begin
        test_q <= wdata_i[3];
        temp_q <= wdata_i[2];
      end
    end
  end

  assign bank_o = bank_q;
  assign stop_o = stop_q;
  assign test_o = test_q;
  assign temp_o = temp_q;
  assign adj_o  = adj_q;

  p_shared_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i >= A_EXT) |=> $stable({bank_q, stop_q, test_q, temp_q}));
  p_adj_from_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_q |-> $past(we_i && addr_i == A_CTRL && wdata_i[0]));
endmodule

// File: rtl/rtc_bank_regfile.sv
module rtc_bank_regfile
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_TICKS    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NIB_W-1:0]    wdata_i,
  input  logic [TMR_W-1:0]    tmr_cnt_i,
  output logic [NIB_W-1:0]    rdata_o,
  output logic                busy_o,
  output logic                upd_o,
  output logic                adj_o,
  output logic                stop_o
);
  logic [1:0] bank;
  logic       test_b, temp_b;
  nib_t       mask, stored;
  logic       tmr_ro;
  logic [N_BANK-1:0][N_BANKED-1:0][NIB_W-1:0] mem_q;

  rtc_shared_ctrl u_ctrl (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .bank_o(bank), .stop_o, .test_o(test_b), .temp_o(temp_b), .adj_o
  );

  rtc_busy_gen #(.TICKS_PER_SEC(TICKS_PER_SEC), .BUSY_TICKS(BUSY_TICKS)) u_busy (
    .clk_i, .rst_ni, .tick_i, .busy_o, .upd_o
  );

  rtc_access_map u_map (
    .bank_i(bank), .addr_i, .mask_o(mask), .tmr_ro_o(tmr_ro)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q       <= '0;
      mem_q[0][1] <= 4'b1000;   // oscillator-stop flag set at power-on
    end else begin
      for (int b = 0; b < N_BANK; b++)
        for (int a = 0; a < N_BANKED; a++)
          if (we_i && bank == 2'(b) && addr_i == ADDR_W'(a))
            mem_q[b][a] <= (mem_q[b][a] & ~mask) | (wdata_i & mask);
    end
  end

  always_comb begin
    stored = '0;
    for (int b = 0; b < N_BANK; b++)
      for (int a = 0; a < N_BANKED; a++)
        if (bank == 2'(b) && addr_i == ADDR_W'(a)) stored = mem_q[b][a];
  end

  always_comb begin
    if (addr_i == A_CTRL)      rdata_o = {bank, stop_o, busy_o};
    else if (addr_i == A_EXT)  rdata_o = {test_b, temp_b, stored[1:0] & mask[1:0]};
    else if (tmr_ro)           rdata_o = addr_i[0] ? tmr_cnt_i[7:4] : tmr_cnt_i[3:0];
    else                       rdata_o = stored & mask;
  end

  p_no_write_leak_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
  p_bank3_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank == 2'd3 && addr_i < A_EXT) |-> rdata_o == '0);
  p_busy_visible_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL) |-> rdata_o[0] == busy_o);
endmodule

// File: tb/tb_rtc_bank_regfile.sv
module tb_rtc_bank_regfile;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [3:0] wdata_i = '0;
  logic [7:0] tmr_cnt_i = 8'hA5;
  logic [3:0] rdata_o;
  logic       busy_o, upd_o, adj_o, stop_o;

  int n_run = 0;
  int n_fail = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic       chk = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  rtc_bank_regfile #(.TICKS_PER_SEC(64), .BUSY_TICKS(8)) dut (
    .clk_i(clk), .rst_ni, .tick_i, .we_i, .addr_i, .wdata_i, .tmr_cnt_i,
    .rdata_o, .busy_o, .upd_o, .adj_o, .stop_o
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(posedge clk); #1;
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] exp, input string tag);
    @(posedge clk); #1;
    addr_i = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    chk = 1'b1;
    @(posedge clk); #1;
    chk = 1'b0;
  endtask

  // monitor: pops expected reads and compares at the falling edge
  always @(negedge clk) begin
    if (chk && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata_o, e);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R8 reset state
    rd(4'h1, 4'h8, "R8 fos set");
    rd(4'h0, 4'h0, "R8 sec zero");
    rd(4'hF, 4'h0, "R8 ctrl zero");
    rd(4'hE, 4'h0, "R8 ext zero");

    // R6 fixed-zero bits
    wr(4'h3, 4'hF); rd(4'h3, 4'h7, "R6 b0 a3");
    wr(4'h5, 4'hF); rd(4'h5, 4'h3, "R6 b0 a5");
    wr(4'h8, 4'hF); rd(4'h8, 4'h3, "R6 b0 a8");
    wr(4'hA, 4'hF); rd(4'hA, 4'h1, "R6 b0 aA");
    wr(4'h0, 4'h3);
    wr(4'hF, 4'b1000);
    wr(4'h2, 4'hF); rd(4'h2, 4'h0, "R6 b2 a2");
    wr(4'h9, 4'hF); rd(4'h9, 4'h0, "R6 b2 a9");

    // R1 separate per-bank storage
    wr(4'h0, 4'hC);
    wr(4'hF, 4'b0100);
    wr(4'h0, 4'h9); rd(4'h0, 4'h9, "R1 b1 a0");
    wr(4'hF, 4'b1000); rd(4'h0, 4'hC, "R1 b2 a0");
    wr(4'hF, 4'b0000); rd(4'h0, 4'h3, "R1 b0 a0");

    // R10 banked low half of E
    wr(4'hE, 4'h3);
    wr(4'hF, 4'b0100); wr(4'hE, 4'h2); rd(4'hE, 4'h2, "R10 b1 E");
    wr(4'hF, 4'b1000); wr(4'hE, 4'h1); rd(4'hE, 4'h1, "R10 b2 E");
    wr(4'hF, 4'b0000); rd(4'hE, 4'h3, "R10 b0 E");

    // R2 shared bits
    wr(4'hE, 4'hF); rd(4'hE, 4'hF, "R2 b0 E");
    wr(4'hF, 4'b1000); rd(4'hE, 4'hD, "R2 b2 E shared");
    wr(4'hF, 4'b1010); rd(4'hF, 4'hA, "R2 stop rd");
    check("R2 stop_o", {3'b0, stop_o}, 4'h1);
    wr(4'hF, 4'b0100); rd(4'hF, 4'h4, "R2 b1 F");

    // R3 adjust pulse, busy unchanged
    wr(4'hF, 4'b0101);
    check("R3 adj pulse", {3'b0, adj_o}, 4'h1);
    check("R3 busy kept", {3'b0, busy_o}, 4'h0);
    @(posedge clk); #1;
    check("R3 adj single", {3'b0, adj_o}, 4'h0);
    rd(4'hF, 4'h4, "R3 busy rd");

    // R7 RAM and fixed zeros in bank 1
    wr(4'h9, 4'hF); rd(4'h9, 4'hF, "R7 b1 a9");
    wr(4'hB, 4'hF); rd(4'hB, 4'hF, "R7 b1 aB");
    wr(4'hC, 4'hF); rd(4'hC, 4'h7, "R6 b1 aC");
    wr(4'hD, 4'hF); rd(4'hD, 4'hB, "R6 b1 aD");
    wr(4'hF, 4'b1000);
    wr(4'hC, 4'h6); rd(4'hC, 4'h6, "R7 b2 aC");

    // R5 timer window read-only
    wr(4'h6, 4'h0); rd(4'h6, 4'h5, "R5 a6");
    wr(4'h7, 4'h0); rd(4'h7, 4'hA, "R5 a7");

    // R9 bank code 3
    wr(4'hF, 4'b1100);
    wr(4'h0, 4'hF); rd(4'h0, 4'h0, "R9 a0");
    wr(4'hE, 4'hF); rd(4'hE, 4'hC, "R9 E shared only");
    rd(4'hF, 4'hC, "R9 F");

    // R4 busy window against a bench tick count
    @(posedge clk); #1;
    addr_i = 4'hF;
    tick_i = 1'b1;
    for (int k = 1; k <= 130; k++) begin
      logic eb, eu;
      @(posedge clk);
      @(negedge clk);
      eb = (k % 64) >= 56;
      eu = (k % 64) == 0;
      if (k % 8 == 0 || (k % 64) >= 55 || (k % 64) <= 1) begin
        check($sformatf("R4 busy k=%0d", k), {3'b0, busy_o}, {3'b0, eb});
        check($sformatf("R4 upd k=%0d", k), {3'b0, upd_o}, {3'b0, eu});
        check($sformatf("R3 rd busy k=%0d", k), {3'b0, rdata_o[0]}, {3'b0, eb});
      end
    end
    @(posedge clk); #1;
    tick_i = 1'b0;

    // R8 reset again
    rst_ni = 1'b0;
    @(posedge clk); #1;
    rst_ni = 1'b1;
    rd(4'hF, 4'h0, "R8 ctrl after reset");
    rd(4'h1, 4'h8, "R8 fos after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule